// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit dual-rail bus and produces one completion signal. Its job is to form the acknowledge of a four-phase handshake. Each bit travels on two wires: a true rail and a false rail. A sender alternates between a data phase and a spacer phase. The detector reports when every pair has finished the current phase. The output does not move until the last pair has made its transition.

A single parameter selects the signalling convention.

- **Return-to-zero:** each pair feeds an OR gate. Data is the one-hot code and the spacer is both rails low.
- **Return-to-one:** each pair feeds an AND gate. Data is the one-cold code and the spacer is both rails high.

The same tree of two-input holding elements merges the per-pair results in both modes. A node takes the value of its two inputs when they agree and keeps its state otherwise. Each node is modelled as a clocked element, so the merge has a fixed latency equal to the tree depth. A second output flags any pair that shows the code that is illegal in the selected mode. This output is for checking only; no recovery is attempted.

Top module: `dr_completion`

## Requirements
- R1: In return-to-zero mode, a pair carries data when exactly one rail is high: true=1/false=0 means 1, true=0/false=1 means 0. Once every pair carries data, `done` becomes 1.
- R2: In return-to-zero mode, once every pair has returned to the spacer (both rails 0), `done` becomes 0.
- R3: In return-to-one mode, the spacer is both rails 1. Once every pair holds the spacer, `done` becomes 1.
- R4: In return-to-one mode, a pair carries data when exactly one rail is low: true=0/false=1 means 1, true=1/false=0 means 0. Once every pair carries data, `done` becomes 0.
- R5: While only some pairs have completed the current phase, `done` keeps its previous value.
- R6: `done` changes exactly LAT clock edges after the input change that completed the phase. LAT = ceil(log2(WIDTH)), with a minimum of 1.
- R7: `code_err` is 1 in the same cycle that any pair shows the illegal code (both rails 1 in return-to-zero, both rails 0 in return-to-one). Otherwise it is 0.
- R8: While reset is held, `done` sits at the spacer level of the mode: 0 for return-to-zero, 1 for return-to-one.
- R9: When WIDTH is not a power of two, the unpaired leaf at each tree level is carried upward. The highest-numbered pair therefore gates completion like every other pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding elements of the tree |
| rst_n | input | 1 | Asynchronous active-low reset to the spacer level |
| rail_t | input | WIDTH | True rail of each pair |
| rail_f | input | WIDTH | False rail of each pair |
| done | output | 1 | Completion signal used as the handshake acknowledge |
| code_err | output | 1 | Some pair shows the illegal code of the mode |

## Verification
The hardest situation to reach from the ports is a partially complete bus. Some pairs have moved to the new phase and others have not, and the output must keep its old value. This is hardest when the missing pair is the odd leaf that is carried through a level on its own.

The bench handles this by sweeping every 5-bit data word in both modes. It moves the pairs one at a time and checks `done` after each step. It raises pairs in ascending order. It lowers them in ascending or descending order, depending on the word, so the last pair to change is sometimes pair 0 and sometimes the pass-through pair. On the completing step it samples `done` one edge before and exactly at the expected latency.

// File: rtl/dr_cd_pkg.sv
package dr_cd_pkg;

  typedef enum logic {
    RZ_MODE = 1'b0,
    RO_MODE = 1'b1
  } dr_mode_e;

  // Number of merge levels; a single pair still gets one holding stage.
  function automatic int tree_levels(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Node count at level l when n leaves are halved per level (ceiling).
  function automatic int level_width(input int n, input int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

  // Value a completed-spacer bus presents to the tree.
  function automatic logic spacer_level(input dr_mode_e m);
    return (m == RO_MODE);
  endfunction

endpackage

// File: rtl/cd_leaf.sv
module cd_leaf
  import dr_cd_pkg::*;
#(
  parameter int       N    = 8,
  parameter dr_mode_e MODE = RZ_MODE
) (
  input  logic [N-1:0] t_rail,
  input  logic [N-1:0] f_rail,
  output logic [N-1:0] leaf,
  output logic [N-1:0] bad
);

  for (genvar i = 0; i < N; i++) begin : g_pair
    if (MODE == RZ_MODE) begin : g_rz
      // data raises one rail, spacer drops both
      assign leaf[i] = t_rail[i] | f_rail[i];
      assign bad[i]  = t_rail[i] & f_rail[i];
    end else begin : g_ro
      // data drops one rail, spacer raises both
      assign leaf[i] = t_rail[i] & f_rail[i];
      assign bad[i]  = ~(t_rail[i] | f_rail[i]);
    end
  end

endmodule

// File: rtl/cd_celem.sv
module cd_celem #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= INIT;
    else if (a == b) q <= a;
  end

  // R5: disagreeing inputs leave the node unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a != b) |=> $stable(q));

  // R6: agreeing inputs are taken one edge later
  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a == b) |=> (q == $past(a)));

endmodule

// File: rtl/cd_tree.sv
module cd_tree
  import dr_cd_pkg::*;
#(
  parameter int       N    = 8,
  parameter dr_mode_e MODE = RZ_MODE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] leaf,
  output logic         root
);

  localparam int   LEVELS = tree_levels(N);
  localparam logic INIT   = spacer_level(MODE);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = level_width(N, l);
    logic [W-1:0] v;
    if (l == 0) begin : g_base
      assign v = leaf;
    end else begin : g_merge
      localparam int WP = level_width(N, l - 1);
      for (genvar i = 0; i < W; i++) begin : g_node
        if (2 * i + 1 < WP) begin : g_pair
          cd_celem #(.INIT(INIT)) u_c (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (g_lvl[l-1].v[2*i]),
            .b    (g_lvl[l-1].v[2*i+1]),
            .q    (v[i])
          );
        end else begin : g_pass
          // R9: odd leaf carried up with the same one-edge delay
          cd_celem #(.INIT(INIT)) u_c (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (g_lvl[l-1].v[2*i]),
            .b    (g_lvl[l-1].v[2*i]),
            .q    (v[i])
          );
        end
      end
    end
  end

  assign root = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/dr_completion.sv
module dr_completion
  import dr_cd_pkg::*;
#(
  parameter int       WIDTH = 8,
  parameter dr_mode_e MODE  = RZ_MODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             done,
  output logic             code_err
);

  localparam logic SPACER = spacer_level(MODE);

  logic [WIDTH-1:0] leaf_w;
  logic [WIDTH-1:0] bad_w;

  cd_leaf #(.N(WIDTH), .MODE(MODE)) u_leaf (
    .t_rail(rail_t),
    .f_rail(rail_f),
    .leaf  (leaf_w),
    .bad   (bad_w)
  );

  cd_tree #(.N(WIDTH), .MODE(MODE)) u_tree (
    .clk  (clk),
    .rst_n(rst_n),
    .leaf (leaf_w),
    .root (done)
  );

  assign code_err = |bad_w;

  // R8: first sampled edge out of reset shows the spacer level
  assert_reset_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (done == SPACER));

  // R1, R4: a legal pair marks data exactly when its rails differ
  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    assert_leaf_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_w[i] |-> (leaf_w[i] == ((rail_t[i] ^ rail_f[i]) ^ SPACER)));
  end

endmodule

// File: tb/dr_completion_test.sv
module dr_completion_test;
  import dr_cd_pkg::*;

  localparam int N = 5;
  localparam int L = (N < 2) ? 1 : $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] zt = '0, zf = '0;
  logic [N-1:0] ot = '1, of = '1;
  logic done_z, err_z, done_o, err_o;
  int n_chk = 0;
  int n_fail = 0;
  logic exp_z = 1'b0;
  logic exp_o = 1'b1;

  always #4 clk = ~clk;

  dr_completion #(.WIDTH(N), .MODE(RZ_MODE)) uut (
    .clk(clk), .rst_n(rst_n), .rail_t(zt), .rail_f(zf),
    .done(done_z), .code_err(err_z));

  dr_completion #(.WIDTH(N), .MODE(RO_MODE)) uut_one (
    .clk(clk), .rst_n(rst_n), .rail_t(ot), .rail_f(of),
    .done(done_o), .code_err(err_o));

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // Pairs in mask carry bit val[i]; the rest hold the spacer.
  task automatic drive(input logic [N-1:0] val, input logic [N-1:0] mask);
    @(posedge clk);
    #1;
    zt = mask & val;
    zf = mask & ~val;
    ot = ~mask | ~val;
    of = ~mask | val;
  endtask

  task automatic settle();
    repeat (L + 1) @(posedge clk);
    @(negedge clk);
  endtask

  // Step on which the last pair completes: check the edge before and at L.
  task automatic finish_step(input string tz, input string to_);
    repeat (L - 1) @(posedge clk);
    @(negedge clk);
    check(done_z, exp_z, "R6 rtz early");
    check(done_o, exp_o, "R6 rto early");
    exp_z = ~exp_z;
    exp_o = ~exp_o;
    @(posedge clk);
    @(negedge clk);
    check(done_z, exp_z, tz);
    check(done_o, exp_o, to_);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done_z, 1'b0, "R8 rtz reset");
    check(done_o, 1'b1, "R8 rto reset");
    check(err_z, 1'b0, "R7 rtz spacer");
    check(err_o, 1'b0, "R7 rto spacer");
    rst_n = 1'b1;
    settle();
    check(done_z, 1'b0, "R8 rtz after reset");
    check(done_o, 1'b1, "R8 rto after reset");

    for (int w = 0; w < (1 << N); w++) begin
      logic [N-1:0] mask;
      mask = '0;
      for (int k = 0; k < N; k++) begin
        mask[k] = 1'b1;
        drive(w[N-1:0], mask);
        if (k < N - 1) begin
          settle();
          check(done_z, exp_z, "R5 R9 rtz partial data");
          check(done_o, exp_o, "R5 R9 rto partial data");
          check(err_z, 1'b0, "R7 rtz legal");
          check(err_o, 1'b0, "R7 rto legal");
        end else begin
          finish_step("R1 rtz all data", "R4 rto all data");
        end
      end
      for (int s = 0; s < N; s++) begin
        int k;
        k = w[0] ? s : (N - 1 - s);
        mask[k] = 1'b0;
        drive(w[N-1:0], mask);
        if (s < N - 1) begin
          settle();
          check(done_z, exp_z, "R5 R9 rtz partial spacer");
          check(done_o, exp_o, "R5 R9 rto partial spacer");
        end else begin
          finish_step("R2 rtz all spacer", "R3 rto all spacer");
        end
      end
    end

    for (int k = 0; k < N; k++) begin
      @(posedge clk);
      #1;
      zt = '0; zf = '0; ot = '1; of = '1;
      zt[k] = 1'b1; zf[k] = 1'b1;
      ot[k] = 1'b0; of[k] = 1'b0;
      @(negedge clk);
      check(err_z, 1'b1, "R7 rtz illegal");
      check(err_o, 1'b1, "R7 rto illegal");
      settle();
      check(done_z, 1'b0, "R5 rtz illegal single pair");
      check(done_o, 1'b1, "R5 rto illegal single pair");
      drive('0, '0);
      @(negedge clk);
      check(err_z, 1'b0, "R7 rtz cleared");
      check(err_o, 1'b0, "R7 rto cleared");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule